// File: doc/BRIEF.md
# Ten-Bit Address Master Sequencer

This block sits between a transfer requester and a byte-level two-wire serial master engine. It turns one request into the ordered list of bus commands the engine carries out: start or repeated start, address bytes, data bytes and stop. A request holds a 10-bit or 7-bit target address, a number of bytes to write and a number of bytes to read. Write data is pulled from a ready/valid stream. Read data is handed out as single-cycle strobes.

A 10-bit target is always addressed first in the write direction, with the header `11110 A[9:8] 0` followed by the low address byte. A read then takes a repeated start and the header alone with the direction bit set. When a request has both write and read bytes, it becomes a combined transfer: the writes go first, then a repeated start turns the bus around, with no stop in between. A request can also ask to keep the bus when it finishes. The next request then opens with a repeated start, and that next request may target a 7-bit or a 10-bit slave. An optional start byte can go before the addressing phase.

The sequencer checks the acknowledge returned for every address byte and every written byte. A missing acknowledge ends the transfer with a stop and an error code.

Top module: `addr10_master_seq`

## Requirements
- R1: After reset, cmd_valid, done and rd_valid are 0 and req_ready is 1.
- R2: A 10-bit request with write bytes and no read bytes produces, in order: START (op 1) or RSTART (op 2), WRITE (op 3) of `{5'b11110, A[9:8], 1'b0}`, WRITE of A[7:0], one WRITE per data byte in stream order, and then STOP (op 5). START, RSTART and STOP commands carry data 0 and nack 0.
- R3: A 10-bit request with read bytes and no write bytes produces: START, WRITE `{11110, A[9:8], 0}`, WRITE A[7:0], RSTART, WRITE `{11110, A[9:8], 1}`, one READ (op 4, data 0) per byte, and then STOP.
- R4: Every READ carries nack 0 except the last READ of a request, which carries nack 1. Each READ response is delivered on rd_data with a one-cycle rd_valid pulse, in order.
- R5: A request with both write and read bytes sends all of its data WRITEs before the RSTART that begins the read phase, and sends no STOP between the two phases.
- R6: A 7-bit target (req_ten = 0) is addressed with `{A[6:0], rw}`. A request with no write bytes and with read bytes sends `{A[6:0], 1}` directly. A request with write bytes, or with no bytes at all, sends `{A[6:0], 0}` first. If read bytes follow, it then sends RSTART and `{A[6:0], 1}`.
- R7: A request with req_hold = 1 that finishes without error issues no STOP and keeps the bus. The next request then begins with RSTART instead of START.
- R8: With req_start_byte = 1, the opening START or RSTART is followed by WRITE 0x01 and then RSTART, and only then by the addressing. The acknowledge returned for the 0x01 byte is ignored.
- R9: A response with rsp_ack = 0 to any address byte is followed immediately by STOP. No further WRITE or READ is issued, and done reports done_err = 1. The STOP is issued even when req_hold = 1.
- R10: A response with rsp_ack = 0 to a data WRITE is followed immediately by STOP. The remaining write bytes are not taken from the stream, and done reports done_err = 2.
- R11: While cmd_valid = 1 and cmd_ready = 0, cmd_valid stays 1 and cmd_op, cmd_data and cmd_nack do not change.
- R12: done is a one-cycle pulse that comes after the last command has been accepted. When no error occurs, done_err = 0. req_ready is 1 in the cycle done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle and able to take a request |
| req_addr | input | 10 | Target address; bits 6:0 are used for a 7-bit target |
| req_ten | input | 1 | 1 selects 10-bit addressing, 0 selects 7-bit addressing |
| req_wr_len | input | LEN_W | Number of bytes to write |
| req_rd_len | input | LEN_W | Number of bytes to read |
| req_start_byte | input | 1 | Send a start byte before addressing |
| req_hold | input | 1 | Keep the bus (no stop) at the end of the request |
| wd_valid | input | 1 | Write byte available |
| wd_ready | output | 1 | Write byte taken this cycle when wd_valid is 1 |
| wd_data | input | 8 | Write byte |
| cmd_valid | output | 1 | Command to the engine valid |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 3 | 1 START, 2 RSTART, 3 WRITE, 4 READ, 5 STOP |
| cmd_data | output | 8 | Byte for WRITE, otherwise 0 |
| cmd_nack | output | 1 | For READ: answer with a not-acknowledge |
| rsp_valid | input | 1 | Engine response for a WRITE or READ |
| rsp_ack | input | 1 | 1 when the slave acknowledged a WRITE |
| rsp_data | input | 8 | Byte received by a READ |
| rd_valid | output | 1 | Read byte strobe |
| rd_data | output | 8 | Read byte |
| done | output | 1 | Request finished (one cycle) |
| done_err | output | 2 | 0 none, 1 address not acknowledged, 2 data not acknowledged |

## Verification
The assertions assume that the engine sends exactly one response for each accepted WRITE or READ. That response comes at least one cycle after the acceptance, and START, RSTART and STOP get no response at all. They also assume that a request is offered only while req_ready is 1. The bench engine model keeps to these rules. It picks its ready randomly, answers only the commands it has taken, after a random delay of one to three cycles, and chooses which WRITE to refuse from a per-request index. The stimulus holds each request for a single cycle while the sequencer is idle.

// File: rtl/a10_pkg.sv
package a10_pkg;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_START  = 3'd1,
    OP_RSTART = 3'd2,
    OP_WRITE  = 3'd3,
    OP_READ   = 3'd4,
    OP_STOP   = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_ADDR = 2'd1,
    ERR_DATA = 2'd2
  } err_e;

  typedef enum logic [4:0] {
    S_IDLE, S_BEGIN, S_SB, S_SB_W, S_SB_RS,
    S_A1, S_A1_W, S_A2, S_A2_W,
    S_WR, S_WR_W, S_RS, S_A3, S_A3_W,
    S_RD, S_RD_W, S_END, S_STOP, S_FIN
  } seq_state_e;

  localparam logic [7:0] START_BYTE = 8'h01;

  function automatic logic [7:0] hdr10(input logic [1:0] hi, input logic rw);
    return {5'b11110, hi, rw};
  endfunction

  function automatic logic [7:0] addr7(input logic [6:0] a, input logic rw);
    return {a, rw};
  endfunction

endpackage

// File: rtl/a10_cmd_slot.sv
module a10_cmd_slot
  import a10_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  op_e        ld_op,
  input  logic [7:0] ld_data,
  input  logic       ld_nack,
  input  logic       cmd_ready,
  output logic       cmd_valid,
  output op_e        cmd_op,
  output logic [7:0] cmd_data,
  output logic       cmd_nack,
  output logic       idle
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_valid <= 1'b0;
      cmd_op    <= OP_NONE;
      cmd_data  <= '0;
      cmd_nack  <= 1'b0;
    end else if (load) begin
      cmd_valid <= 1'b1;
      cmd_op    <= ld_op;
      cmd_data  <= ld_data;
      cmd_nack  <= ld_nack;
    end else if (cmd_ready) begin
      cmd_valid <= 1'b0;
    end
  end

  assign idle = !cmd_valid;

endmodule

// File: rtl/a10_rd_port.sv
module a10_rd_port #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          capture,
  input  logic          rsp_valid,
  input  logic [DW-1:0] rsp_data,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture && rsp_valid;
      if (capture && rsp_valid) rd_data <= rsp_data;
    end
  end

endmodule

// File: rtl/a10_ctrl.sv
module a10_ctrl
  import a10_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [9:0]       req_addr,
  input  logic             req_ten,
  input  logic [LEN_W-1:0] req_wr_len,
  input  logic [LEN_W-1:0] req_rd_len,
  input  logic             req_start_byte,
  input  logic             req_hold,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [7:0]       wd_data,
  input  logic             slot_idle,
  output logic             load,
  output op_e              ld_op,
  output logic [7:0]       ld_data,
  output logic             ld_nack,
  input  logic             rsp_valid,
  input  logic             rsp_ack,
  output logic             rd_capture,
  output logic             done,
  output logic [1:0]       done_err
);

  seq_state_e       state_q, state_d;
  logic [9:0]       addr_q;
  logic             ten_q, sb_q, hold_q, held_q;
  logic [LEN_W-1:0] wl_q, rl_q, wcnt_q, rcnt_q;
  err_e             err_q, err_val;
  logic             take_req, wr_inc, rd_inc, err_set, fin, held_set, held_clr;
  logic             rw7, rd_last, wr_left;

  // 7-bit read with nothing to write: address directly in read direction
  assign rw7     = (wl_q == '0) && (rl_q != '0);
  assign rd_last = (rcnt_q == rl_q - 1'b1);
  assign wr_left = (wcnt_q != wl_q);

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    ld_op    = OP_NONE;
    ld_data  = '0;
    ld_nack  = 1'b0;
    wd_ready = 1'b0;
    take_req = 1'b0;
    wr_inc   = 1'b0;
    rd_inc   = 1'b0;
    err_set  = 1'b0;
    err_val  = ERR_NONE;
    fin      = 1'b0;
    held_set = 1'b0;
    held_clr = 1'b0;
    case (state_q)
      S_IDLE: if (req_valid) begin
        take_req = 1'b1;
        state_d  = S_BEGIN;
      end
      S_BEGIN: if (slot_idle) begin
        load    = 1'b1;
        ld_op   = held_q ? OP_RSTART : OP_START;
        state_d = sb_q ? S_SB : S_A1;
      end
      S_SB: if (slot_idle) begin
        load    = 1'b1;
        ld_op   = OP_WRITE;
        ld_data = START_BYTE;
        state_d = S_SB_W;
      end
      S_SB_W: if (rsp_valid) state_d = S_SB_RS;
      S_SB_RS: if (slot_idle) begin
        load    = 1'b1;
        ld_op   = OP_RSTART;
        state_d = S_A1;
      end
      S_A1: if (slot_idle) begin
        load    = 1'b1;
        ld_op   = OP_WRITE;
        ld_data = ten_q ? hdr10(addr_q[9:8], 1'b0) : addr7(addr_q[6:0], rw7);
        state_d = S_A1_W;
      end
      S_A1_W: if (rsp_valid) begin
        if (!rsp_ack) begin
          err_set = 1'b1;
          err_val = ERR_ADDR;
          state_d = S_STOP;
        end else if (ten_q) begin
          state_d = S_A2;
        end else if (rw7) begin
          state_d = S_RD;
        end else begin
          state_d = S_WR;
        end
      end
      S_A2: if (slot_idle) begin
        load    = 1'b1;
        ld_op   = OP_WRITE;
        ld_data = addr_q[7:0];
        state_d = S_A2_W;
      end
      S_A2_W: if (rsp_valid) begin
        if (!rsp_ack) begin
          err_set = 1'b1;
          err_val = ERR_ADDR;
          state_d = S_STOP;
        end else begin
          state_d = S_WR;
        end
      end
      S_WR: begin
        if (!wr_left) begin
          state_d = (rl_q != '0) ? S_RS : S_END;
        end else if (slot_idle) begin
          wd_ready = 1'b1;
          if (wd_valid) begin
            load    = 1'b1;
            ld_op   = OP_WRITE;
            ld_data = wd_data;
            wr_inc  = 1'b1;
            state_d = S_WR_W;
          end
        end
      end
      S_WR_W: if (rsp_valid) begin
        if (!rsp_ack) begin
          err_set = 1'b1;
          err_val = ERR_DATA;
          state_d = S_STOP;
        end else begin
          state_d = S_WR;
        end
      end
      S_RS: if (slot_idle) begin
        load    = 1'b1;
        ld_op   = OP_RSTART;
        state_d = S_A3;
      end
      S_A3: if (slot_idle) begin
        load    = 1'b1;
        ld_op   = OP_WRITE;
        ld_data = ten_q ? hdr10(addr_q[9:8], 1'b1) : addr7(addr_q[6:0], 1'b1);
        state_d = S_A3_W;
      end
      S_A3_W: if (rsp_valid) begin
        if (!rsp_ack) begin
          err_set = 1'b1;
          err_val = ERR_ADDR;
          state_d = S_STOP;
        end else begin
          state_d = S_RD;
        end
      end
      S_RD: if (slot_idle) begin
        load    = 1'b1;
        ld_op   = OP_READ;
        ld_nack = rd_last;
        rd_inc  = 1'b1;
        state_d = S_RD_W;
      end
      S_RD_W: if (rsp_valid) begin
        state_d = (rcnt_q == rl_q) ? S_END : S_RD;
      end
      S_END: begin
        if (hold_q) begin
          held_set = 1'b1;
          state_d  = S_FIN;
        end else begin
          state_d = S_STOP;
        end
      end
      S_STOP: if (slot_idle) begin
        load     = 1'b1;
        ld_op    = OP_STOP;
        held_clr = 1'b1;
        state_d  = S_FIN;
      end
      S_FIN: if (slot_idle) begin
        fin     = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      addr_q   <= '0;
      ten_q    <= 1'b0;
      sb_q     <= 1'b0;
      hold_q   <= 1'b0;
      held_q   <= 1'b0;
      wl_q     <= '0;
      rl_q     <= '0;
      wcnt_q   <= '0;
      rcnt_q   <= '0;
      err_q    <= ERR_NONE;
      done     <= 1'b0;
      done_err <= 2'd0;
    end else begin
      state_q <= state_d;
      done    <= fin;
      if (fin) done_err <= err_q;
      if (take_req) begin
        addr_q <= req_addr;
        ten_q  <= req_ten;
        sb_q   <= req_start_byte;
        hold_q <= req_hold;
        wl_q   <= req_wr_len;
        rl_q   <= req_rd_len;
        wcnt_q <= '0;
        rcnt_q <= '0;
        err_q  <= ERR_NONE;
      end
      if (wr_inc) wcnt_q <= wcnt_q + 1'b1;
      if (rd_inc) rcnt_q <= rcnt_q + 1'b1;
      if (err_set) err_q <= err_val;
      if (held_set) held_q <= 1'b1;
      if (held_clr) held_q <= 1'b0;
    end
  end

  assign req_ready  = (state_q == S_IDLE);
  assign rd_capture = (state_q == S_RD_W);

endmodule

// File: rtl/addr10_master_seq.sv
module addr10_master_seq
  import a10_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [9:0]       req_addr,
  input  logic             req_ten,
  input  logic [LEN_W-1:0] req_wr_len,
  input  logic [LEN_W-1:0] req_rd_len,
  input  logic             req_start_byte,
  input  logic             req_hold,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [7:0]       wd_data,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [2:0]       cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_nack,
  input  logic             rsp_valid,
  input  logic             rsp_ack,
  input  logic [7:0]       rsp_data,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic [1:0]       done_err
);

  logic       slot_idle, load, ld_nack, rd_capture;
  op_e        ld_op, op_q;
  logic [7:0] ld_data;

  a10_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_ten        (req_ten),
    .req_wr_len     (req_wr_len),
    .req_rd_len     (req_rd_len),
    .req_start_byte (req_start_byte),
    .req_hold       (req_hold),
    .wd_valid       (wd_valid),
    .wd_ready       (wd_ready),
    .wd_data        (wd_data),
    .slot_idle      (slot_idle),
    .load           (load),
    .ld_op          (ld_op),
    .ld_data        (ld_data),
    .ld_nack        (ld_nack),
    .rsp_valid      (rsp_valid),
    .rsp_ack        (rsp_ack),
    .rd_capture     (rd_capture),
    .done           (done),
    .done_err       (done_err)
  );

  a10_cmd_slot u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .ld_op     (ld_op),
    .ld_data   (ld_data),
    .ld_nack   (ld_nack),
    .cmd_ready (cmd_ready),
    .cmd_valid (cmd_valid),
    .cmd_op    (op_q),
    .cmd_data  (cmd_data),
    .cmd_nack  (cmd_nack),
    .idle      (slot_idle)
  );

  assign cmd_op = op_q;

  a10_rd_port #(.DW(8)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .capture   (rd_capture),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data)
  );

endmodule

// File: rtl/a10_seq_chk.sv
module a10_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       cmd_valid,
  input logic       cmd_ready,
  input logic [2:0] cmd_op,
  input logic [7:0] cmd_data,
  input logic       cmd_nack,
  input logic       rsp_valid,
  input logic       rd_valid,
  input logic       done,
  input logic [1:0] done_err
);

  logic [2:0] last_op;

  always_ff @(posedge clk) begin
    if (rst) last_op <= 3'd0;
    else if (cmd_valid && cmd_ready) last_op <= cmd_op;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!cmd_valid && !done && !rd_valid && req_ready));

  p_cmd_stable_r11: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && !cmd_ready) |=>
      (cmd_valid && $stable(cmd_op) && $stable(cmd_data) && $stable(cmd_nack)));

  p_done_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_idle_r12: assert property (@(posedge clk) disable iff (rst)
    done |-> (!cmd_valid && req_ready));

  p_err_stop_r9: assert property (@(posedge clk) disable iff (rst)
    (done && done_err != 2'd0) |-> (last_op == 3'd5));

  p_rd_from_rsp_r4: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rsp_valid));

endmodule

bind addr10_master_seq a10_seq_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_data  (cmd_data),
  .cmd_nack  (cmd_nack),
  .rsp_valid (rsp_valid),
  .rd_valid  (rd_valid),
  .done      (done),
  .done_err  (done_err)
);

// File: tb/addr10_master_seq_test.sv
module addr10_master_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 8;
  localparam logic [2:0] C_ST = 3'd1, C_RS = 3'd2, C_WR = 3'd3, C_RD = 3'd4, C_SP = 3'd5;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_ready;
  logic [9:0] req_addr = '0;
  logic req_ten = 1'b0, req_start_byte = 1'b0, req_hold = 1'b0;
  logic [LEN_W-1:0] req_wr_len = '0, req_rd_len = '0;
  logic wd_valid = 1'b1, wd_ready;
  logic [7:0] wd_data;
  logic cmd_valid, cmd_ready = 1'b0, cmd_nack;
  logic [2:0] cmd_op;
  logic [7:0] cmd_data;
  logic rsp_valid = 1'b0, rsp_ack = 1'b0;
  logic [7:0] rsp_data = '0;
  logic rd_valid, done;
  logic [7:0] rd_data;
  logic [1:0] done_err;

  addr10_master_seq #(.LEN_W(LEN_W)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_ten(req_ten), .req_wr_len(req_wr_len),
    .req_rd_len(req_rd_len), .req_start_byte(req_start_byte), .req_hold(req_hold),
    .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .cmd_nack(cmd_nack), .rsp_valid(rsp_valid),
    .rsp_ack(rsp_ack), .rsp_data(rsp_data), .rd_valid(rd_valid),
    .rd_data(rd_data), .done(done), .done_err(done_err)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  bit finished = 0;

  // engine model state
  logic [11:0] log_w [0:127];
  int log_n = 0;
  logic [7:0] wq [0:63];
  int wptr = 0;
  bit wpend = 0;
  logic [7:0] rd_given [0:63];
  logic [7:0] rd_got [0:63];
  int rd_given_n = 0, rd_got_n = 0;
  int nack_at = -1, wr_seen = 0;
  int rsp_cd = 0;
  logic pend_ack = 1'b1;
  logic [7:0] pend_data = '0;
  bit prev_stall = 0;
  logic [11:0] stall_w = '0;
  int stab_bad = 0;
  int done_cnt = 0;
  logic [1:0] last_err = '0;
  logic rr_at_done = 1'b0;

  assign wd_data = wq[wptr];

  // expected sequence
  logic [11:0] exp_w [0:127];
  int exp_n = 0;
  int exp_err = 0;
  int widx = 0;
  bit ex_ab = 0;
  bit held = 0;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // engine: ready, acceptance log, responses, write stream, monitors
  initial begin
    forever begin
      @(negedge clk);
      rsp_valid = 1'b0;
      if (rsp_cd > 0) begin
        rsp_cd--;
        if (rsp_cd == 0) begin
          rsp_valid = 1'b1;
          rsp_ack   = pend_ack;
          rsp_data  = pend_data;
        end
      end
      if (prev_stall && !(cmd_valid && {cmd_op, cmd_nack, cmd_data} == stall_w)) stab_bad++;
      if (wpend) begin wptr++; wpend = 0; end
      if (wd_ready && wd_valid) wpend = 1;
      if (rd_valid) begin rd_got[rd_got_n] = rd_data; rd_got_n++; end
      if (done) begin done_cnt++; last_err = done_err; rr_at_done = req_ready; end
      cmd_ready = ($urandom % 3) != 0;
      if (cmd_valid && cmd_ready && !rst) begin
        log_w[log_n] = {cmd_op, cmd_nack, cmd_data};
        log_n++;
        if (cmd_op == C_WR) begin
          pend_ack = !(wr_seen == nack_at);
          wr_seen++;
          rsp_cd = 1 + ($urandom % 3);
        end else if (cmd_op == C_RD) begin
          pend_data = 8'($urandom);
          pend_ack = 1'b1;
          rd_given[rd_given_n] = pend_data;
          rd_given_n++;
          rsp_cd = 1 + ($urandom % 3);
        end
      end
      prev_stall = cmd_valid && !cmd_ready && !rst;
      stall_w = {cmd_op, cmd_nack, cmd_data};
    end
  end

  task automatic add_op(input logic [2:0] op, input logic nk, input logic [7:0] d);
    exp_w[exp_n] = {op, nk, d};
    exp_n++;
  endtask

  // kind: 0 ignored ack, 1 address byte, 2 data byte
  task automatic add_wr(input logic [7:0] d, input int kind);
    if (!ex_ab) begin
      add_op(C_WR, 1'b0, d);
      if (widx == nack_at && kind != 0) begin
        exp_err = kind;
        ex_ab = 1;
      end
      widx++;
    end
  endtask

  task automatic build_exp(input logic [9:0] a, input bit ten, input int wl, input int rl,
                           input bit sb, input bit hold);
    bit direct;
    exp_n = 0; exp_err = 0; widx = 0; ex_ab = 0; direct = 0;
    add_op(held ? C_RS : C_ST, 1'b0, 8'h00);
    if (sb) begin add_wr(8'h01, 0); add_op(C_RS, 1'b0, 8'h00); end
    if (ten) begin
      add_wr({5'b11110, a[9:8], 1'b0}, 1);
      add_wr(a[7:0], 1);
    end else if (wl > 0 || rl == 0) begin
      add_wr({a[6:0], 1'b0}, 1);
    end else begin
      add_wr({a[6:0], 1'b1}, 1);
      direct = 1;
    end
    if (!direct) begin
      for (int i = 0; i < wl; i++) add_wr(wq[i], 2);
      if (!ex_ab && rl > 0) begin
        add_op(C_RS, 1'b0, 8'h00);
        add_wr(ten ? {5'b11110, a[9:8], 1'b1} : {a[6:0], 1'b1}, 1);
      end
    end
    if (!ex_ab) for (int i = 0; i < rl; i++) add_op(C_RD, (i == rl - 1), 8'h00);
    if (!ex_ab && hold) held = 1;
    else begin add_op(C_SP, 1'b0, 8'h00); held = 0; end
  endtask

  task automatic run_txn(input string tag, input logic [9:0] a, input bit ten, input int wl,
                         input int rl, input bit sb, input bit hold, input int nk);
    int start_cnt, t, bad;
    bit ok;
    @(negedge clk);
    log_n = 0; wr_seen = 0; rd_given_n = 0; rd_got_n = 0; wptr = 0; wpend = 0;
    nack_at = nk;
    for (int i = 0; i < 64; i++) wq[i] = 8'($urandom);
    build_exp(a, ten, wl, rl, sb, hold);
    start_cnt = done_cnt;
    req_addr = a; req_ten = ten; req_wr_len = LEN_W'(wl); req_rd_len = LEN_W'(rl);
    req_start_byte = sb; req_hold = hold; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    t = 0;
    while (done_cnt == start_cnt && t < 3000) begin @(negedge clk); t++; end
    if (done_cnt == start_cnt) begin
      chk(0, tag, "no done (timeout)", 0, 1);
      return;
    end
    ok = (log_n == exp_n);
    bad = -1;
    for (int i = 0; i < exp_n && i < log_n; i++)
      if (bad < 0 && log_w[i] !== exp_w[i]) bad = i;
    if (bad >= 0) ok = 0;
    if (bad >= 0) chk(ok, tag, "command sequence", int'(log_w[bad]), int'(exp_w[bad]));
    else chk(ok, tag, "command count", log_n, exp_n);
    chk(int'(last_err) == exp_err, tag, "done_err", int'(last_err), exp_err);
    chk(rr_at_done === 1'b1, "R12", "req_ready with done", int'(rr_at_done), 1);
    if (rl > 0 && exp_err == 0) begin
      ok = (rd_got_n == rl) && (rd_given_n == rl);
      bad = -1;
      for (int i = 0; i < rl && i < rd_got_n; i++)
        if (bad < 0 && rd_got[i] !== rd_given[i]) bad = i;
      if (bad >= 0) chk(0, "R4", "read data", int'(rd_got[bad]), int'(rd_given[bad]));
      else chk(ok, "R4", "read count", rd_got_n, rl);
    end
    if (exp_err == 2) chk(wptr == nk - (ten ? 2 : 1) - (sb ? 1 : 0) + 1, "R10",
                          "write bytes taken", wptr, nk - (ten ? 2 : 1) - (sb ? 1 : 0) + 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!cmd_valid && !done && !rd_valid && req_ready, "R1", "reset outputs",
        {cmd_valid, done, rd_valid, req_ready}, 4'b0001);

    run_txn("R2", 10'h2A5, 1, 3, 0, 0, 0, -1);
    run_txn("R3", 10'h1C3, 1, 0, 4, 0, 0, -1);
    run_txn("R4", 10'h3FF, 1, 0, 1, 0, 0, -1);
    run_txn("R5", 10'h0F0, 1, 2, 2, 0, 0, -1);
    run_txn("R6", 10'h05A, 0, 2, 0, 0, 0, -1);
    run_txn("R6", 10'h033, 0, 0, 3, 0, 0, -1);
    run_txn("R6", 10'h07F, 0, 1, 2, 0, 0, -1);
    run_txn("R6", 10'h011, 0, 0, 0, 0, 0, -1);
    run_txn("R7", 10'h155, 1, 2, 0, 0, 1, -1);
    run_txn("R7", 10'h02C, 0, 0, 2, 0, 0, -1);
    run_txn("R8", 10'h2B1, 1, 1, 1, 1, 0, 0);
    run_txn("R9", 10'h301, 1, 2, 2, 0, 1, 1);
    run_txn("R9", 10'h122, 1, 0, 2, 0, 0, 2);
    run_txn("R9", 10'h044, 0, 1, 0, 0, 0, 0);
    run_txn("R10", 10'h0AB, 1, 4, 1, 0, 0, 3);
    run_txn("R10", 10'h019, 0, 3, 0, 1, 1, 3);

    for (int k = 0; k < 40; k++) begin
      run_txn("R2", 10'($urandom), 1'($urandom), int'($urandom % 5), int'($urandom % 5),
              ($urandom % 4) == 0, ($urandom % 4) == 0,
              (($urandom % 3) == 0) ? int'($urandom % 6) : -1);
    end
    run_txn("R7", 10'h200, 1, 1, 0, 0, 0, -1);

    chk(stab_bad == 0, "R11", "stalled command changes", stab_bad, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule